// File: doc/BRIEF.md
# PCIe Transmit Credit Tracker

This block sits on the application side of a PCIe transaction layer and decides whether an outgoing TLP fits in the link partner's receive buffers. It keeps six credit pools, a header pool and a data pool for each of the posted, non-posted and completion classes. Each pool has its own initialization handshake. The pool clears its counter, raises its ready output, and collects the credits released while the partner's init indicator is high. It opens for traffic when that indicator falls. A release pulse with a zero count during initialization marks the pool as unlimited.

The transmit side presents a request: a class and a payload length in dwords. The block answers with a combinational grant. When the application sends a granted TLP in that cycle, the block takes one header credit and the data credits of the payload from the class's pools. The payload needs ceiling(length / 4) data credits. A release and a consumption that land in the same cycle both take effect.

Top module: `pcie_tx_credit_tracker`

## Requirements
- R1: While reset is held, every init-ready output and the grant are low. In the first cycle after reset, all six ready outputs rise, and every pool starts with zero credits and is not unlimited.
- R2: A pool's ready output is high from the cycle after its counter was cleared until the cycle after its init input falls. It then drops and the pool opens.
- R3: Bit 0 of every 3-bit vector (release valid, init, ready) is posted, bit 1 is non-posted and bit 2 is completion. The request class uses the code 0 for posted, 1 for non-posted and 2 for completion. Code 3 is never granted.
- R4: The header release count packs 2 bits per class: [1:0] posted, [3:2] non-posted, [5:4] completion. The data release count packs 4 bits per class: [3:0] posted, [7:4] non-posted, [11:8] completion.
- R5: A class's count field has no effect in a cycle where that class's release valid bit is low.
- R6: Credits released while init is high form the pool's starting total. Credits released after init falls add to the running count.
- R7: A release pulse with a zero count while init is high makes the pool unlimited. An unlimited pool never blocks a grant and is never reduced.
- R8: Every TLP takes exactly one header credit of its class. A header pool at zero blocks the grant.
- R9: A TLP of length L dwords needs ceiling(L/4) data credits. L = 0 needs none.
- R10: The grant is high only when both pools of the requested class are open and each holds enough credits or is unlimited.
- R11: A send with the grant high deducts credits. A send with the grant low changes nothing. A release and a deduction in the same cycle give old + released - consumed.
- R12: Init rising on an open pool closes it, clears its count and unlimited mark, and restarts the handshake.
- R13: The counters are at least 12 bits wide. A data pool holding more than 256 credits grants a 1024-dword TLP without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_rel_vld | input | 3 | Header credit release valid per class |
| hdr_rel_cnt | input | 6 | Packed header credits released |
| hdr_init_phase | input | 3 | Header credit initialization indicator per class |
| hdr_init_rdy | output | 3 | Header pool ready for initialization |
| dat_rel_vld | input | 3 | Data credit release valid per class |
| dat_rel_cnt | input | 12 | Packed data credits released |
| dat_init_phase | input | 3 | Data credit initialization indicator per class |
| dat_init_rdy | output | 3 | Data pool ready for initialization |
| req_class | input | 2 | Class of the candidate TLP |
| req_len_dw | input | 11 | Payload length in dwords (0 = none) |
| tlp_grant | output | 1 | Candidate TLP may be sent |
| tlp_send | input | 1 | Candidate TLP is sent this cycle |

## Verification
Directed cases run first and use lengths on the rounding edge: 0, 4n and 4n+1 dwords. Each of these lands exactly at a pool's count or one above it, which separates correct rounding from truncation and separates >= from >. A zero-count pulse is placed on one header class and on a different data class, so a wrong field slice or bit order grants or blocks the wrong class. Garbage count fields with their valid bit low, sends made without a grant, and a release landing in the same cycle as a consumption each show whether an input that should be inert leaks into a counter. A random phase follows with random fields, lengths, sends and rare re-initializations. It is compared every cycle against a reference model of the pools.

// File: rtl/pcie_crd_pkg.sv
package pcie_crd_pkg;

   localparam int CRD_NUM_CLS = 3;

   typedef enum logic [1:0] {
      CLS_POSTED = 2'd0,
      CLS_NONPOST = 2'd1,
      CLS_CPL = 2'd2
   } crd_cls_e;

   typedef enum logic [1:0] {
      PH_CLEAR = 2'd0,
      PH_ARMED = 2'd1,
      PH_RUN = 2'd2
   } crd_phase_e;

endpackage

// File: rtl/credit_init_ctl.sv
module credit_init_ctl
   import pcie_crd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   output crd_phase_e phase
);

   logic init_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_CLEAR;
         init_q <= 1'b0;
      end else begin
         init_q <= init;
         unique case (phase)
            PH_CLEAR: phase <= PH_ARMED;
            PH_ARMED: if (init_q && !init) phase <= PH_RUN;
            PH_RUN:   if (init) phase <= PH_CLEAR;
            default:  phase <= PH_CLEAR;
         endcase
      end
   end

endmodule

// File: rtl/credit_pool.sv
module credit_pool
   import pcie_crd_pkg::*;
#(
   parameter int FIELD_W = 2,
   parameter int AVAIL_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init,
   input  logic               rel_vld,
   input  logic [FIELD_W-1:0] rel_amt,
   input  logic               take,
   input  logic [AVAIL_W-1:0] take_amt,
   output logic               ready,
   output logic               done,
   output logic               unlimited,
   output logic [AVAIL_W-1:0] avail
);

   if (FIELD_W < 1 || FIELD_W >= AVAIL_W) begin : g_bad_field
      $error("credit_pool: FIELD_W must be in 1..AVAIL_W-1");
   end

   crd_phase_e         phase;
   logic [AVAIL_W-1:0] add_amt;
   logic [AVAIL_W-1:0] sub_amt;
   logic               inf_mark;

   credit_init_ctl u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (init),
      .phase (phase)
   );

   assign ready    = (phase == PH_ARMED);
   assign done     = (phase == PH_RUN);
   assign add_amt  = (rel_vld && phase != PH_CLEAR) ? AVAIL_W'(rel_amt) : '0;
   assign sub_amt  = (take && phase == PH_RUN && !unlimited) ? take_amt : '0;
   assign inf_mark = (phase == PH_ARMED) && init && rel_vld && (rel_amt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         avail     <= '0;
         unlimited <= 1'b0;
      end else if (phase == PH_CLEAR) begin
         avail     <= '0;
         unlimited <= 1'b0;
      end else begin
         avail <= avail + add_amt - sub_amt;
         if (inf_mark) unlimited <= 1'b1;
      end
   end

endmodule

// File: rtl/credit_need.sv
module credit_need #(
   parameter int LEN_W         = 11,
   parameter int DW_PER_CREDIT = 4
) (
   input  logic [LEN_W-1:0] len_dw,
   output logic [LEN_W-1:0] credits
);

   localparam int SH = $clog2(DW_PER_CREDIT);

   if ((1 << SH) != DW_PER_CREDIT) begin : g_bad_unit
      $error("credit_need: DW_PER_CREDIT must be a power of two");
   end

   if (DW_PER_CREDIT == 1) begin : g_unit
      assign credits = len_dw;
   end else begin : g_round
      logic [LEN_W:0] sum;
      assign sum     = {1'b0, len_dw} + (LEN_W+1)'(DW_PER_CREDIT - 1);
      assign credits = LEN_W'(sum >> SH);
   end

endmodule

// File: rtl/pcie_tx_credit_tracker.sv
module pcie_tx_credit_tracker
   import pcie_crd_pkg::*;
#(
   parameter int HDR_FIELD_W   = 2,
   parameter int DAT_FIELD_W   = 4,
   parameter int AVAIL_W       = 12,
   parameter int LEN_W         = 11,
   parameter int DW_PER_CREDIT = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [CRD_NUM_CLS-1:0]             hdr_rel_vld,
   input  logic [CRD_NUM_CLS*HDR_FIELD_W-1:0] hdr_rel_cnt,
   input  logic [CRD_NUM_CLS-1:0]             hdr_init_phase,
   output logic [CRD_NUM_CLS-1:0]             hdr_init_rdy,
   input  logic [CRD_NUM_CLS-1:0]             dat_rel_vld,
   input  logic [CRD_NUM_CLS*DAT_FIELD_W-1:0] dat_rel_cnt,
   input  logic [CRD_NUM_CLS-1:0]             dat_init_phase,
   output logic [CRD_NUM_CLS-1:0]             dat_init_rdy,
   input  logic [1:0]                         req_class,
   input  logic [LEN_W-1:0]                   req_len_dw,
   output logic                               tlp_grant,
   input  logic                               tlp_send
);

   localparam int NCLS = CRD_NUM_CLS;

   if (AVAIL_W < 12) begin : g_bad_avail
      $error("pcie_tx_credit_tracker: AVAIL_W must be at least 12");
   end
   if (AVAIL_W < LEN_W) begin : g_bad_len
      $error("pcie_tx_credit_tracker: AVAIL_W must cover LEN_W");
   end

   logic [NCLS-1:0]              h_done, d_done, h_unl, d_unl, h_cons, d_cons;
   logic [NCLS-1:0][AVAIL_W-1:0] h_avail, d_avail;
   logic [LEN_W-1:0]             d_need;
   logic [1:0]                   idx;
   logic                         cls_ok, hdr_ok, dat_ok, fire;

   credit_need #(
      .LEN_W         (LEN_W),
      .DW_PER_CREDIT (DW_PER_CREDIT)
   ) u_need (
      .len_dw  (req_len_dw),
      .credits (d_need)
   );

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      credit_pool #(
         .FIELD_W (HDR_FIELD_W),
         .AVAIL_W (AVAIL_W)
      ) u_hdr (
         .clk       (clk),
         .rst_n     (rst_n),
         .init      (hdr_init_phase[c]),
         .rel_vld   (hdr_rel_vld[c]),
         .rel_amt   (hdr_rel_cnt[c*HDR_FIELD_W +: HDR_FIELD_W]),
         .take      (h_cons[c]),
         .take_amt  (AVAIL_W'(1)),
         .ready     (hdr_init_rdy[c]),
         .done      (h_done[c]),
         .unlimited (h_unl[c]),
         .avail     (h_avail[c])
      );

      credit_pool #(
         .FIELD_W (DAT_FIELD_W),
         .AVAIL_W (AVAIL_W)
      ) u_dat (
         .clk       (clk),
         .rst_n     (rst_n),
         .init      (dat_init_phase[c]),
         .rel_vld   (dat_rel_vld[c]),
         .rel_amt   (dat_rel_cnt[c*DAT_FIELD_W +: DAT_FIELD_W]),
         .take      (d_cons[c]),
         .take_amt  (AVAIL_W'(d_need)),
         .ready     (dat_init_rdy[c]),
         .done      (d_done[c]),
         .unlimited (d_unl[c]),
         .avail     (d_avail[c])
      );

      assign h_cons[c] = fire && (idx == 2'(c));
      assign d_cons[c] = fire && (idx == 2'(c));
   end

   always_comb begin
      cls_ok    = (req_class < 2'(NCLS));
      idx       = cls_ok ? req_class : 2'd0;
      hdr_ok    = h_done[idx] && (h_unl[idx] || h_avail[idx] != '0);
      dat_ok    = d_done[idx] && (d_unl[idx] || d_avail[idx] >= AVAIL_W'(d_need));
      tlp_grant = cls_ok && hdr_ok && dat_ok;
      fire      = tlp_send && tlp_grant;
   end

endmodule

// File: rtl/pcie_crd_chk.sv
module pcie_crd_chk #(
   parameter int HDR_FIELD_W = 2,
   parameter int DAT_FIELD_W = 4,
   parameter int AVAIL_W     = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [2:0]             h_vld,
   input logic [3*HDR_FIELD_W-1:0] h_cnt,
   input logic [2:0]             h_init,
   input logic [2:0]             h_rdy,
   input logic [2:0]             d_vld,
   input logic [3*DAT_FIELD_W-1:0] d_cnt,
   input logic [2:0]             d_init,
   input logic [2:0]             d_rdy,
   input logic [1:0]             req_class,
   input logic                   grant,
   input logic                   send,
   input logic [2:0]             h_done,
   input logic [2:0]             d_done,
   input logic [2:0]             h_unl,
   input logic [2:0]             d_unl,
   input logic [2:0][AVAIL_W-1:0] h_avail,
   input logic [2:0][AVAIL_W-1:0] d_avail
);

   assert_bad_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_class != 2'd3);

   assert_grant_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && req_class != 2'd3) |-> (h_done[req_class] && d_done[req_class]));

   for (genvar c = 0; c < 3; c++) begin : g_c
      assert_hdr_rdy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(h_rdy[c]) |-> (h_avail[c] == '0 && !h_unl[c]));
      assert_dat_rdy_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(d_rdy[c]) |-> (d_avail[c] == '0 && !d_unl[c]));

      assert_hdr_inf_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(h_unl[c]) |-> $past(h_vld[c] && h_init[c] &&
                                   h_cnt[c*HDR_FIELD_W +: HDR_FIELD_W] == '0));
      assert_dat_inf_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(d_unl[c]) |-> $past(d_vld[c] && d_init[c] &&
                                   d_cnt[c*DAT_FIELD_W +: DAT_FIELD_W] == '0));

      assert_hdr_novld_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!h_vld[c] && !(send && grant)) |->
            (h_avail[c] == $past(h_avail[c]) || h_avail[c] == '0));
      assert_dat_novld_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(!d_vld[c] && !(send && grant)) |->
            (d_avail[c] == $past(d_avail[c]) || d_avail[c] == '0));

      assert_dat_no_wrap_R13: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(d_vld[c] && !send && d_done[c]) && d_done[c]) |->
            d_avail[c] >= $past(d_avail[c]));
   end

endmodule

bind pcie_tx_credit_tracker pcie_crd_chk #(
   .HDR_FIELD_W (HDR_FIELD_W),
   .DAT_FIELD_W (DAT_FIELD_W),
   .AVAIL_W     (AVAIL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_vld     (hdr_rel_vld),
   .h_cnt     (hdr_rel_cnt),
   .h_init    (hdr_init_phase),
   .h_rdy     (hdr_init_rdy),
   .d_vld     (dat_rel_vld),
   .d_cnt     (dat_rel_cnt),
   .d_init    (dat_init_phase),
   .d_rdy     (dat_init_rdy),
   .req_class (req_class),
   .grant     (tlp_grant),
   .send      (tlp_send),
   .h_done    (h_done),
   .d_done    (d_done),
   .h_unl     (h_unl),
   .d_unl     (d_unl),
   .h_avail   (h_avail),
   .d_avail   (d_avail)
);

// File: tb/tb_pcie_tx_credit_tracker.sv
`timescale 1ns/1ps
module tb_pcie_tx_credit_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  h_vld = '0, h_init = '0, h_rdy;
   logic [5:0]  h_cnt = '0;
   logic [2:0]  d_vld = '0, d_init = '0, d_rdy;
   logic [11:0] d_cnt = '0;
   logic [1:0]  req_class = '0;
   logic [10:0] req_len = '0;
   logic        grant;
   logic        send = 1'b0;

   int errors = 0;
   int checks = 0;

   int m_cnt [6];
   bit m_unl [6];
   int m_st  [6];
   bit m_iq  [6];

   always #5 clk = ~clk;

   pcie_tx_credit_tracker dut (
      .clk (clk), .rst_n (rst_n),
      .hdr_rel_vld (h_vld), .hdr_rel_cnt (h_cnt),
      .hdr_init_phase (h_init), .hdr_init_rdy (h_rdy),
      .dat_rel_vld (d_vld), .dat_rel_cnt (d_cnt),
      .dat_init_phase (d_init), .dat_init_rdy (d_rdy),
      .req_class (req_class), .req_len_dw (req_len),
      .tlp_grant (grant), .tlp_send (send)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int need_of(int len);
      return (len + 3) / 4;
   endfunction

   function automatic bit exp_grant();
      int c;
      if (req_class == 2'd3) return 1'b0;
      c = int'(req_class);
      return m_st[c] == 2 && m_st[c+3] == 2 &&
             (m_unl[c] || m_cnt[c] >= 1) &&
             (m_unl[c+3] || m_cnt[c+3] >= need_of(int'(req_len)));
   endfunction

   function automatic logic [2:0] exp_rdy(bit data);
      logic [2:0] r;
      for (int c = 0; c < 3; c++) r[c] = (m_st[data ? c+3 : c] == 1);
      return r;
   endfunction

   task automatic model_update();
      bit g;
      int need;
      g = exp_grant();
      need = need_of(int'(req_len));
      for (int i = 0; i < 6; i++) begin
         int c, amt, tamt;
         bit hdr, vld, ini, take;
         c    = i % 3;
         hdr  = (i < 3);
         vld  = hdr ? h_vld[c] : d_vld[c];
         amt  = hdr ? int'(h_cnt[2*c +: 2]) : int'(d_cnt[4*c +: 4]);
         ini  = hdr ? h_init[c] : d_init[c];
         take = send && g && (int'(req_class) == c);
         tamt = hdr ? 1 : need;
         case (m_st[i])
            0: begin m_cnt[i] = 0; m_unl[i] = 0; m_st[i] = 1; end
            1: begin
               if (ini && vld && amt == 0) m_unl[i] = 1;
               if (vld) m_cnt[i] += amt;
               if (m_iq[i] && !ini) m_st[i] = 2;
            end
            default: begin
               if (vld) m_cnt[i] += amt;
               if (take && !m_unl[i]) m_cnt[i] -= tamt;
               if (ini) m_st[i] = 0;
            end
         endcase
         m_iq[i] = ini;
      end
   endtask

   // One clock: compare against the model, advance it, return at the next negedge.
   task automatic step();
      #1;
      chk(grant == exp_grant(), "R10 grant vs model", int'(grant), int'(exp_grant()));
      chk(h_rdy == exp_rdy(0), "R2 header ready", int'(h_rdy), int'(exp_rdy(0)));
      chk(d_rdy == exp_rdy(1), "R2 data ready", int'(d_rdy), int'(exp_rdy(1)));
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic expect_grant(int cls, int len, bit exp, string req);
      req_class = 2'(cls);
      req_len   = 11'(len);
      #1;
      chk(grant == exp, req, int'(grant), int'(exp));
   endtask

   task automatic send_one(int cls, int len);
      req_class = 2'(cls);
      req_len   = 11'(len);
      send = 1'b1;
      step();
      send = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int reinit [6];
      void'($urandom(32'd4242));
      for (int i = 0; i < 6; i++) begin
         m_cnt[i] = 0; m_unl[i] = 0; m_st[i] = 0; m_iq[i] = 0; reinit[i] = 0;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(h_rdy == 3'b000 && d_rdy == 3'b000, "R1 ready low in reset", int'({h_rdy, d_rdy}), 0);
      chk(grant == 1'b0, "R1 grant low in reset", int'(grant), 0);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      #1;
      chk(h_rdy == 3'b111 && d_rdy == 3'b111, "R1 ready after reset", int'({h_rdy, d_rdy}), 63);

      // initialization: posted hdr 6, np hdr 2, cpl hdr infinite; posted data 30, np data infinite, cpl data 10
      h_init = 3'b111; d_init = 3'b111;
      step();
      h_vld = 3'b111; h_cnt = 6'b00_10_11;
      d_vld = 3'b111; d_cnt = 12'hA0F;
      step();
      h_vld = 3'b001; h_cnt = 6'b111111;
      d_vld = 3'b001; d_cnt = 12'hFFF;
      step();
      h_vld = 3'b000; d_vld = 3'b000;
      step();
      expect_grant(0, 0, 1'b0, "R2 blocked during init");
      h_init = 3'b000; d_init = 3'b000;
      h_cnt = '0; d_cnt = '0;
      step();
      #1;
      chk(h_rdy == 3'b000 && d_rdy == 3'b000, "R2 ready drops after init", int'({h_rdy, d_rdy}), 0);

      expect_grant(0, 0, 1'b1, "R9 zero length posted");
      expect_grant(0, 120, 1'b1, "R6 R9 posted data exactly 30");
      expect_grant(0, 121, 1'b0, "R5 R9 posted data 31 blocked");
      expect_grant(1, 1024, 1'b1, "R7 R4 np data unlimited");
      expect_grant(2, 40, 1'b1, "R4 cpl data 10");
      expect_grant(2, 41, 1'b0, "R4 cpl data 11 blocked");
      expect_grant(3, 0, 1'b0, "R3 class 3 never granted");

      send_one(1, 0);
      send_one(1, 0);
      expect_grant(1, 0, 1'b0, "R8 np header exhausted");

      for (int k = 0; k < 4; k++) begin
         expect_grant(2, 0, 1'b1, "R7 cpl header unlimited");
         send_one(2, 0);
      end

      send_one(2, 41);
      expect_grant(2, 40, 1'b1, "R11 send without grant ignored");

      d_vld = 3'b001; d_cnt = 12'h005;
      send_one(0, 120);
      d_vld = 3'b000; d_cnt = '0;
      expect_grant(0, 20, 1'b1, "R11 release with consume gives 5");
      expect_grant(0, 21, 1'b0, "R11 release with consume not 6");

      d_vld = 3'b001; d_cnt = 12'h00F;
      req_class = 2'd2; req_len = '0;
      for (int k = 0; k < 20; k++) step();
      d_vld = 3'b000; d_cnt = '0;
      expect_grant(0, 1024, 1'b1, "R13 305 credits cover 1024 dwords");
      send_one(0, 1024);
      expect_grant(0, 196, 1'b1, "R13 49 left");
      expect_grant(0, 197, 1'b0, "R13 50 not available");

      h_init = 3'b001;
      step();
      expect_grant(0, 0, 1'b0, "R12 reinit blocks grant");
      step();
      #1;
      chk(h_rdy == 3'b001, "R12 ready after reinit clear", int'(h_rdy), 1);
      h_vld = 3'b001; h_cnt = 6'b000010;
      step();
      h_vld = 3'b000; h_cnt = '0; h_init = 3'b000;
      step();
      expect_grant(0, 196, 1'b1, "R12 reopened with data untouched");
      send_one(0, 0);
      send_one(0, 0);
      expect_grant(0, 0, 1'b0, "R12 count restarted from zero");

      for (int n = 0; n < 600; n++) begin
         logic [11:0] r;
         r = 12'($urandom);
         h_vld = 3'($urandom); h_cnt = 6'($urandom);
         d_vld = 3'($urandom); d_cnt = r;
         for (int i = 0; i < 6; i++) begin
            if (reinit[i] == 0 && ($urandom % 300) == 0) reinit[i] = 3;
         end
         for (int c = 0; c < 3; c++) begin
            h_init[c] = (reinit[c] != 0);
            d_init[c] = (reinit[c+3] != 0);
         end
         req_class = 2'($urandom);
         req_len   = (($urandom % 4) == 0) ? 11'($urandom % 9) : 11'($urandom % 1025);
         send      = 1'($urandom);
         step();
         for (int i = 0; i < 6; i++) if (reinit[i] != 0) reinit[i]--;
      end
      send = 1'b0; h_vld = '0; d_vld = '0; h_init = '0; d_init = '0;
      step();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule